// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Level Flags

This block is a first-in first-out buffer whose write side and read side run on two clocks that need not share any phase or frequency relation. Words are 9 bits wide. The depth is a power of two set by an address-width parameter. Writes are taken on rising edges of the write clock and reads on rising edges of the read clock. A read loads the oldest word into a registered output, and that register drives a data bus which an output-enable input can release.

Four active-low status outputs report the fill level. The write-clock side produces full and almost-full. The read-clock side produces empty and almost-empty. The two almost thresholds come in as inputs from a separate offset block. One auxiliary write input is sampled while reset is held, and that sample sets its role until the next reset. If the sample is high, the input becomes a second, active-high write enable, which lets devices be combined for more depth. If the sample is low, the input is ignored and the main write enable alone controls writes. The pointers cross between the domains in Gray code through multi-stage synchronizers.

Top module: `xclk_fifo_pf`

## Requirements
- R1: While reset is low and after it is released with no traffic, empty_n and almost_empty_n are 0, full_n and almost_full_n are 1, and the output register reads all zeros.
- R2: Words leave in the order they were accepted and keep their value, including while writes and reads run at the same time on the two clocks.
- R3: full_n goes to 0 once DEPTH words are held with no reads. Writes attempted while full_n is 0 change nothing.
- R4: A read happens only when rd_en_a_n and rd_en_b_n are both 0 and empty_n is 1. Read attempts with only one enable low, or while empty, leave the output register unchanged.
- R5: empty_n returns to 1 some read-clock cycles after a write into an empty buffer. full_n returns to 1 some write-clock cycles after one read from a full buffer.
- R6: If wr_aux is 1 while reset is low, a write needs wr_en_n = 0 and wr_aux = 1. Attempts with wr_aux = 0 store nothing.
- R7: If wr_aux is 0 while reset is low, wr_en_n = 0 alone performs a write, whatever wr_aux does afterwards.
- R8: almost_empty_n is 0 exactly when the stored count is less than or equal to ae_thresh.
- R9: almost_full_n is 0 exactly when the stored count is greater than or equal to DEPTH minus af_thresh.
- R10: When out_en_n is 1, q_o does not drive the output register value (it is high impedance). When out_en_n is 0, q_o equals the output register.
- R11: The output register changes only on a rising read-clock edge at which a read happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock, may be unrelated to wclk |
| rst_n | input | 1 | Asynchronous active-low reset, released separately in each domain |
| d_i | input | DW | Write data |
| wr_en_n | input | 1 | Main write enable, active low |
| wr_aux | input | 1 | Sampled at reset: role select; afterwards a second active-high write enable when it was high |
| rd_en_a_n | input | 1 | First read enable, active low |
| rd_en_b_n | input | 1 | Second read enable, active low |
| out_en_n | input | 1 | Output bus enable, active low |
| ae_thresh | input | AW | Almost-empty threshold in words |
| af_thresh | input | AW | Almost-full distance from DEPTH in words |
| q_o | output | DW | Read data bus, high impedance when disabled |
| full_n | output | 1 | Full, active low, write-clock domain |
| almost_full_n | output | 1 | Almost full, active low, write-clock domain |
| empty_n | output | 1 | Empty, active low, read-clock domain |
| almost_empty_n | output | 1 | Almost empty, active low, read-clock domain |

## Verification
A write and a read can land in the same interval on the two unrelated clocks. The hardest case is a write accepted at the same write edge where the full flag clears because of a read the read side made a few edges earlier. The bench runs the clocks at unrelated periods. It drives a random-gapped writer that is faster than a random-gapped reader, so the buffer keeps filling to full and draining from it. The driver predicts acceptance only from the full flag it sees before each edge. The monitor compares every word the reader gets against that prediction, so a write that is dropped, duplicated or accepted while full shows up as a data mismatch.

// File: rtl/xfifo_pkg.sv
`timescale 1ns/1ps
package xfifo_pkg;
  // role of the auxiliary write input, captured while reset is held
  typedef enum logic {
    WMODE_SINGLE = 1'b0,  // aux input ignored
    WMODE_DUAL   = 1'b1   // aux input is a second active-high enable
  } wmode_e;
endpackage

// File: rtl/xfifo_rst_sync.sv
`timescale 1ns/1ps
module xfifo_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sh_q[STAGES-1];
endmodule

// File: rtl/xfifo_sync.sv
`timescale 1ns/1ps
module xfifo_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= {st_q[STAGES-2:0], d};
  end

  assign q = st_q[STAGES-1];
endmodule

// File: rtl/xfifo_wr_ctl.sv
`timescale 1ns/1ps
module xfifo_wr_ctl
  import xfifo_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en_n,
  input  logic          wr_aux,
  input  logic [AW-1:0] af_thresh,
  input  logic [AW:0]   rgray_s,
  output logic          mem_we,
  output logic [AW-1:0] waddr,
  output logic [AW:0]   wgray_q,
  output logic          full_q,
  output logic          afull_q
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  wmode_e        mode_q;
  logic          wr_req;
  logic [PW-1:0] wptr_q, wptr_d, wgray_d, rbin, wcnt_d;
  logic          full_d, afull_d;

  // role capture: loads only while the domain reset is held
  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= wmode_e'(wr_aux);
  end

  always_comb begin
    wr_req  = !wr_en_n && ((mode_q == WMODE_DUAL) ? wr_aux : 1'b1);
    mem_we  = wr_req && !full_q;
    wptr_d  = wptr_q + PW'(mem_we);
    wgray_d = wptr_d ^ (wptr_d >> 1);
    rbin[PW-1] = rgray_s[PW-1];
    for (int i = PW - 2; i >= 0; i--) rbin[i] = rbin[i+1] ^ rgray_s[i];
    wcnt_d  = wptr_d - rbin;
    full_d  = (wcnt_d == PW'(DEPTH));
    afull_d = (wcnt_d >= (PW'(DEPTH) - {1'b0, af_thresh}));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q  <= '0;
      wgray_q <= '0;
      full_q  <= 1'b0;
      afull_q <= 1'b0;
    end else begin
      wptr_q  <= wptr_d;
      wgray_q <= wgray_d;
      full_q  <= full_d;
      afull_q <= afull_d;
    end
  end

  assign waddr = wptr_q[AW-1:0];

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    full_q |=> $stable(wptr_q));

  a_r9_full_is_almost_full: assert property (@(posedge clk) disable iff (!rst_n)
    full_q |-> afull_q);

  a_r6_role_held: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(mode_q));

  a_r6_aux_gates_write: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == WMODE_DUAL && !wr_aux) |=> $stable(wptr_q));
endmodule

// File: rtl/xfifo_rd_ctl.sv
`timescale 1ns/1ps
module xfifo_rd_ctl #(
  parameter int AW = 10,
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en_a_n,
  input  logic          rd_en_b_n,
  input  logic [AW-1:0] ae_thresh,
  input  logic [AW:0]   wgray_s,
  input  logic [DW-1:0] rdata,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   rgray_q,
  output logic [DW-1:0] dout_q,
  output logic          empty_q,
  output logic          aempty_q
);
  localparam int PW = AW + 1;

  logic          rd_fire;
  logic [PW-1:0] rptr_q, rptr_d, rgray_d, wbin, rcnt_d;
  logic [DW-1:0] dout_d;
  logic          empty_d, aempty_d;

  always_comb begin
    rd_fire = !rd_en_a_n && !rd_en_b_n && !empty_q;
    rptr_d  = rptr_q + PW'(rd_fire);
    rgray_d = rptr_d ^ (rptr_d >> 1);
    wbin[PW-1] = wgray_s[PW-1];
    for (int i = PW - 2; i >= 0; i--) wbin[i] = wbin[i+1] ^ wgray_s[i];
    rcnt_d   = wbin - rptr_d;
    empty_d  = (rcnt_d == '0);
    aempty_d = (rcnt_d <= {1'b0, ae_thresh});
    dout_d   = rd_fire ? rdata : dout_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr_q   <= '0;
      rgray_q  <= '0;
      dout_q   <= '0;
      empty_q  <= 1'b1;
      aempty_q <= 1'b1;
    end else begin
      rptr_q   <= rptr_d;
      rgray_q  <= rgray_d;
      dout_q   <= dout_d;
      empty_q  <= empty_d;
      aempty_q <= aempty_d;
    end
  end

  assign raddr = rptr_q[AW-1:0];

  a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    empty_q |=> $stable(rptr_q));

  a_r11_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_a_n || rd_en_b_n) |=> $stable(dout_q));

  a_r8_empty_is_almost_empty: assert property (@(posedge clk) disable iff (!rst_n)
    empty_q |-> aempty_q);
endmodule

// File: rtl/xclk_fifo_pf.sv
`timescale 1ns/1ps
module xclk_fifo_pf #(
  parameter int DW       = 9,
  parameter int AW       = 10,
  parameter int SYNC_STG = 2
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic [DW-1:0] d_i,
  input  logic          wr_en_n,
  input  logic          wr_aux,
  input  logic          rd_en_a_n,
  input  logic          rd_en_b_n,
  input  logic          out_en_n,
  input  logic [AW-1:0] ae_thresh,
  input  logic [AW-1:0] af_thresh,
  output logic [DW-1:0] q_o,
  output logic          full_n,
  output logic          almost_full_n,
  output logic          empty_n,
  output logic          almost_empty_n
);
  localparam int DEPTH = 1 << AW;
  localparam int PW    = AW + 1;
  localparam int NDOM  = 2;  // index 0 write domain, 1 read domain

  logic [NDOM-1:0] dom_clk, dom_rst_n;
  logic [PW-1:0]   wgray, wgray_s, rgray, rgray_s;
  logic [AW-1:0]   waddr, raddr;
  logic            mem_we, full_q, afull_q, empty_q, aempty_q;
  logic [DW-1:0]   dout, rdata;
  logic [DW-1:0]   mem_q [DEPTH];

  assign dom_clk = {rclk, wclk};

  for (genvar g = 0; g < NDOM; g++) begin : g_rst
    xfifo_rst_sync #(.STAGES(SYNC_STG)) u_rsync (
      .clk    (dom_clk[g]),
      .arst_n (rst_n),
      .srst_n (dom_rst_n[g])
    );
  end

  xfifo_wr_ctl #(.AW(AW)) u_wr (
    .clk       (wclk),
    .rst_n     (dom_rst_n[0]),
    .wr_en_n   (wr_en_n),
    .wr_aux    (wr_aux),
    .af_thresh (af_thresh),
    .rgray_s   (rgray_s),
    .mem_we    (mem_we),
    .waddr     (waddr),
    .wgray_q   (wgray),
    .full_q    (full_q),
    .afull_q   (afull_q)
  );

  xfifo_sync #(.W(PW), .STAGES(SYNC_STG)) u_w2r (
    .clk   (rclk),
    .rst_n (dom_rst_n[1]),
    .d     (wgray),
    .q     (wgray_s)
  );

  xfifo_sync #(.W(PW), .STAGES(SYNC_STG)) u_r2w (
    .clk   (wclk),
    .rst_n (dom_rst_n[0]),
    .d     (rgray),
    .q     (rgray_s)
  );

  xfifo_rd_ctl #(.AW(AW), .DW(DW)) u_rd (
    .clk       (rclk),
    .rst_n     (dom_rst_n[1]),
    .rd_en_a_n (rd_en_a_n),
    .rd_en_b_n (rd_en_b_n),
    .ae_thresh (ae_thresh),
    .wgray_s   (wgray_s),
    .rdata     (rdata),
    .raddr     (raddr),
    .rgray_q   (rgray),
    .dout_q    (dout),
    .empty_q   (empty_q),
    .aempty_q  (aempty_q)
  );

  always_ff @(posedge wclk) begin
    if (mem_we) mem_q[waddr] <= d_i;
  end

  assign rdata          = mem_q[raddr];
  assign q_o            = out_en_n ? {DW{1'bz}} : dout;
  assign full_n         = !full_q;
  assign almost_full_n  = !afull_q;
  assign empty_n        = !empty_q;
  assign almost_empty_n = !aempty_q;
endmodule

// File: tb/xclk_fifo_pf_tb.sv
`timescale 1ns/1ps
module xclk_fifo_pf_tb;
  localparam int DW    = 9;
  localparam int AW    = 10;
  localparam int DEPTH = 1 << AW;
  localparam int AE    = 4;
  localparam int AF    = 3;

  logic wclk = 1'b0, rclk = 1'b0;
  logic rst_n, wr_en_n, wr_aux, rd_en_a_n, rd_en_b_n, out_en_n;
  logic [DW-1:0] d_i, q_o;
  logic [AW-1:0] ae_thresh, af_thresh;
  logic full_n, almost_full_n, empty_n, almost_empty_n;

  int errs = 0, nchk = 0;
  logic [DW-1:0] expq [$];
  int  wr_left = 0, rd_left = 0, rd_style = 0;
  bit  wr_gap = 1'b0, dual = 1'b0;
  logic [DW-1:0] last_q = '0;

  always #4 wclk = ~wclk;   // 125 MHz
  always #7 rclk = ~rclk;   // unrelated read clock

  xclk_fifo_pf #(.DW(DW), .AW(AW)) u_dut (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .d_i(d_i),
    .wr_en_n(wr_en_n), .wr_aux(wr_aux),
    .rd_en_a_n(rd_en_a_n), .rd_en_b_n(rd_en_b_n), .out_en_n(out_en_n),
    .ae_thresh(ae_thresh), .af_thresh(af_thresh), .q_o(q_o),
    .full_n(full_n), .almost_full_n(almost_full_n),
    .empty_n(empty_n), .almost_empty_n(almost_empty_n)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wsettle(input int n);
    repeat (n) @(negedge wclk);
  endtask

  task automatic rsettle(input int n);
    repeat (n) @(negedge rclk);
  endtask

  task automatic wait_wr;
    while (wr_left > 0) @(negedge wclk);
  endtask

  // driver: predicts acceptance from full_n seen before the edge
  initial begin
    wr_en_n = 1'b1;
    d_i     = '0;
    forever begin
      @(negedge wclk);
      if (wr_left > 0 && (!wr_gap || $urandom_range(0, 2) != 0)) begin
        wr_en_n = 1'b0;
        d_i     = DW'($urandom_range(1, (1 << DW) - 1));
        wr_left--;
        if (full_n && (!dual || wr_aux)) expq.push_back(d_i);
      end else begin
        wr_en_n = 1'b1;
      end
    end
  end

  // monitor: a read fired at the last edge is compared here (R2, R4)
  initial begin
    bit pend;
    logic [DW-1:0] e;
    pend = 1'b0;
    rd_en_a_n = 1'b1;
    rd_en_b_n = 1'b1;
    forever begin
      @(negedge rclk);
      if (pend) begin
        if (expq.size() == 0) begin
          chk(1'b0, "R2 read with nothing expected", int'(q_o), 0);
        end else begin
          e = expq.pop_front();
          chk(q_o === e, "R2 order and value", int'(q_o), int'(e));
        end
        last_q = q_o;
      end
      rd_en_a_n = 1'b1;
      rd_en_b_n = 1'b1;
      if (rd_left > 0) begin
        case (rd_style)
          1: begin rd_en_a_n = 1'b0; rd_en_b_n = 1'b0; end
          2: begin
               rd_en_a_n = ($urandom_range(0, 3) == 0);
               rd_en_b_n = ($urandom_range(0, 3) == 0);
             end
          3: begin rd_en_a_n = 1'b0; rd_en_b_n = 1'b1; end
          default: ;
        endcase
      end
      pend = !rd_en_a_n && !rd_en_b_n && empty_n;
      if (pend) rd_left--;
    end
  end

  task automatic do_reset(input bit aux);
    wr_aux = aux;
    dual   = aux;
    rst_n  = 1'b0;
    wsettle(4);
    rsettle(4);
    chk(empty_n === 1'b0, "R1 empty during reset", int'(empty_n), 0);
    chk(almost_empty_n === 1'b0, "R1 almost empty during reset", int'(almost_empty_n), 0);
    chk(full_n === 1'b1, "R1 full inactive during reset", int'(full_n), 1);
    chk(almost_full_n === 1'b1, "R1 almost full inactive during reset", int'(almost_full_n), 1);
    rst_n = 1'b1;
    rsettle(6);
  endtask

  initial begin
    out_en_n  = 1'b0;
    ae_thresh = AW'(AE);
    af_thresh = AW'(AF);
    wr_aux    = 1'b0;
    rst_n     = 1'b0;

    do_reset(1'b0);
    chk(q_o === '0, "R1 output zero after reset", int'(q_o), 0);
    chk(empty_n === 1'b0, "R1 empty after release", int'(empty_n), 0);

    // reads on an empty buffer do nothing
    rd_style = 1; rd_left = 5;
    rsettle(8);
    chk(q_o === '0, "R4 read while empty holds output", int'(q_o), 0);
    chk(empty_n === 1'b0, "R4 still empty", int'(empty_n), 0);
    rd_left = 0;

    // single-enable role: aux low, only wr_en_n needed
    wr_left = AE;
    wait_wr();
    rsettle(8);
    chk(empty_n === 1'b1, "R7 R5 write with main enable only", int'(empty_n), 1);
    chk(almost_empty_n === 1'b0, "R8 count at threshold", int'(almost_empty_n), 0);
    wr_left = 1;
    wait_wr();
    rsettle(8);
    chk(almost_empty_n === 1'b1, "R8 count above threshold", int'(almost_empty_n), 1);

    // one read enable alone
    rd_style = 3; rd_left = 5;
    rsettle(10);
    chk(q_o === '0, "R4 one enable low holds output", int'(q_o), 0);
    chk(almost_empty_n === 1'b1, "R4 count unchanged", int'(almost_empty_n), 1);

    // drain, then extra attempts on empty
    rd_style = 1; rd_left = AE + 1 + 4;
    while (expq.size() != 0) @(negedge rclk);
    rsettle(10);
    chk(empty_n === 1'b0, "R5 empty after drain", int'(empty_n), 0);
    chk(almost_empty_n === 1'b0, "R8 empty is almost empty", int'(almost_empty_n), 0);
    chk(q_o === last_q, "R11 output held on empty reads", int'(q_o), int'(last_q));
    rd_left = 0;

    // fill towards full
    wr_left = DEPTH - AF - 1;
    wait_wr();
    wsettle(10);
    chk(almost_full_n === 1'b1, "R9 below threshold", int'(almost_full_n), 1);
    chk(full_n === 1'b1, "R3 not yet full", int'(full_n), 1);
    wr_left = 1;
    wait_wr();
    wsettle(10);
    chk(almost_full_n === 1'b0, "R9 at threshold", int'(almost_full_n), 0);
    wr_left = AF + 6;
    wait_wr();
    wsettle(10);
    chk(full_n === 1'b0, "R3 full at depth", int'(full_n), 0);
    chk(expq.size() == DEPTH, "R3 accepted word count", expq.size(), DEPTH);

    // one read releases full
    rd_style = 1; rd_left = 1;
    while (rd_left > 0) @(negedge rclk);
    wsettle(10);
    chk(full_n === 1'b1, "R5 full clears after a read", int'(full_n), 1);
    chk(almost_full_n === 1'b0, "R9 still above threshold", int'(almost_full_n), 0);

    // concurrent streaming: writer outruns reader, full toggles
    wr_gap = 1'b1; rd_style = 2; rd_left = 100000;
    wr_left = 300;
    wait_wr();
    wr_gap = 1'b0;
    while (expq.size() != 0) @(negedge rclk);
    rd_left = 0;
    rsettle(10);
    chk(empty_n === 1'b0, "R2 stream fully drained", int'(empty_n), 0);

    // output enable
    out_en_n = 1'b1;
    rsettle(1);
    chk(q_o !== last_q, "R10 bus released", int'(q_o), int'(last_q));
    out_en_n = 1'b0;
    rsettle(1);
    chk(q_o === last_q, "R10 bus driven", int'(q_o), int'(last_q));

    // dual-enable role: aux high at reset
    do_reset(1'b1);
    wr_aux = 1'b0;
    wr_left = 3;
    wait_wr();
    rsettle(10);
    chk(empty_n === 1'b0, "R6 aux low blocks writes", int'(empty_n), 0);
    wr_aux = 1'b1;
    wr_left = 3;
    wait_wr();
    rsettle(10);
    chk(empty_n === 1'b1, "R6 aux high allows writes", int'(empty_n), 1);
    rd_style = 1; rd_left = 3;
    while (expq.size() != 0) @(negedge rclk);
    rsettle(10);
    chk(empty_n === 1'b0, "R6 three words read back", int'(empty_n), 0);

    $display("Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  end

  initial begin
    #1000000;
    errs++;
    nchk++;
    $display("FAIL watchdog all requirements actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  end
endmodule